// File: doc/BRIEF.md
# SPI Master with Stop and Freeze Handshake

This block is a serial peripheral interface master. It sends fixed 8-bit words MSB first and captures the returning serial data. It drives the serial clock and one of six active-low chip selects. The host pushes a data word and a chip-select index through a valid/ready handshake. The received word comes back on a one-cycle strobe at the end of each frame.

Two controls can park the block at a frame boundary.

- **Stop request.** A power-management request is acknowledged at once. The block lets the frame in flight run to the end. It then grants permission to gate its clock.
- **Freeze.** A freeze-enable configuration bit qualifies a debug-mode input. When both are high, serial traffic pauses at the next frame boundary.

When the request or the freeze clears, normal operation resumes.

Top module: `spi_stop_master`

## Requirements
- R1: After synchronous reset, all six `cs_n` lines are high, `sck` is low, and `rx_valid`, `stop_ack` and `clk_stop_ok` are low. With no stop request and no active freeze, `in_ready` is high.
- R2: A word is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The frame is 8 bits, MSB first. Exactly 32 clock cycles after the accepting edge, `rx_valid` pulses for one cycle, and `rx_data` holds the 8 bits sampled on `sin`.
- R3: Throughout a frame, only line `cs_n[in_cs]` is low (index 0 to 5 selects line 0 to 5), and all other lines stay high. Between frames, all lines are high.
- R4: `sck` runs at one quarter of the clock rate, with 2 cycles low then 2 cycles high, starting low (mode 0). `sout` presents bit 7 from the cycle after acceptance, and moves to the next bit on each falling `sck` edge. `sin` is sampled on each rising `sck` edge. `sck` stays low outside frames.
- R5: `stop_ack` follows `stop_req` with a one-cycle delay, both when it rises and when it falls.
- R6: A stop request that arrives during a frame does not cut the frame short. The chip select stays low, and the full word is returned on `rx_valid`.
- R7: `clk_stop_ok` is high only while a stop request is held and the block sits at a frame boundary.
  - If the request arrives during a frame, `clk_stop_ok` rises on the frame's last edge.
  - If the request arrives while idle, it rises one cycle later.
  - While `clk_stop_ok` is high, all chip selects are high and `sck` is low.
- R8: While stopped or frozen, `in_ready` is low and no frame starts, even with `in_valid` held high.
- R9: With `freeze_en` = 1 and `dbg_mode` = 1, `in_ready` drops while idle, and `clk_stop_ok` stays low. A freeze raised during a frame takes effect only after that frame completes.
- R10: With `freeze_en` = 0, `dbg_mode` has no effect: words are accepted and frames complete normally.
- R11: When the stop request is removed or the freeze clears, `in_ready` returns and the next pushed word is sent normally. `clk_stop_ok` falls one cycle after the request is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_en | input | 1 | Configuration bit: lets debug mode freeze transfers |
| dbg_mode | input | 1 | Chip is in debug mode |
| stop_req | input | 1 | Power-management stop request |
| stop_ack | output | 1 | Acknowledge of the stop request |
| clk_stop_ok | output | 1 | Protocol clock may be shut off |
| in_valid | input | 1 | Host word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 8 | Word to transmit |
| in_cs | input | 3 | Chip-select index, 0 to 5 |
| rx_valid | output | 1 | One-cycle strobe: received word valid |
| rx_data | output | 8 | Received word |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| cs_n | output | 6 | Active-low chip selects |

## Verification
All timing is counted from the accepting edge.
- `sout` carries bit 7 one cycle after that edge.
- `sck` first rises after 3 cycles and first falls after 5 cycles.
- `rx_valid`, the release of the chip selects and, under a held stop request, `clk_stop_ok` all appear together 33 cycles after acceptance.
- `stop_ack` and the fall of `clk_stop_ok` lag the `stop_req` transition by one cycle.

The bench drives inputs just after a rising edge and samples on falling edges. It counts falling edges from the accepting edge, so each check lands in exactly the cycle where the result is due. With `sin` looped back to `sout`, `rx_data` must equal the word sent.

// File: rtl/spi_stop_pkg.sv
package spi_stop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_HALT = 2'd2
  } spi_state_t;
endpackage

// File: rtl/spi_sck_phase.sv
module spi_sck_phase #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sck,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int PER = 2 * HALF;
  localparam int CW  = $clog2(PER);

  logic [CW-1:0] cnt;

  assign rise_stb = run && (cnt == CW'(HALF - 1));
  assign fall_stb = run && (cnt == CW'(PER - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else begin
      cnt <= fall_stb ? '0 : cnt + 1'b1;
      if (rise_stb)      sck <= 1'b1;
      else if (fall_stb) sck <= 1'b0;
    end
  end

  // R4: serial clock is low whenever the divider is not running
  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sck);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rise_stb,
  input  logic         fall_stb,
  input  logic         sin,
  output logic         sout,
  output logic         frame_end,
  output logic         rx_valid,
  output logic [W-1:0] rx_data
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  tx_sh;
  logic [W-1:0]  rx_sh;
  logic [BW-1:0] bit_cnt;

  assign sout      = tx_sh[W-1];
  assign frame_end = fall_stb && (bit_cnt == BW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      bit_cnt  <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= frame_end;
      if (load) begin
        tx_sh   <= load_data;
        bit_cnt <= '0;
      end else begin
        if (rise_stb) rx_sh <= {rx_sh[W-2:0], sin};
        if (fall_stb) begin
          tx_sh   <= {tx_sh[W-2:0], 1'b0};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (frame_end) rx_data <= rx_sh;
    end
  end

  // R2: the received strobe lasts exactly one cycle
  assert_rx_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/spi_cs_dec.sv
module spi_cs_dec #(
  parameter int NCS = 6,
  parameter int CSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [CSW-1:0] idx,
  input  logic           release_cs,
  output logic [NCS-1:0] cs_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)             cs_n[i] <= 1'b1;
      else if (load)       cs_n[i] <= (idx != CSW'(i));
      else if (release_cs) cs_n[i] <= 1'b1;
    end
  end

  // R3: never more than one chip select asserted
  assert_one_select_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_stop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       freeze_en,
  input  logic       dbg_mode,
  input  logic       stop_req,
  input  logic       in_valid,
  input  logic       frame_end,
  output logic       in_ready,
  output logic       load,
  output logic       run,
  output logic       stop_ack,
  output logic       clk_stop_ok
);
  spi_state_t state, nxt;
  logic halt_cond;

  assign halt_cond = stop_req || (freeze_en && dbg_mode);
  assign in_ready  = (state == ST_IDLE) && !halt_cond;
  assign load      = in_ready && in_valid;
  assign run       = (state == ST_XFER);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (halt_cond) nxt = ST_HALT;
               else if (in_valid) nxt = ST_XFER;
      ST_XFER: if (frame_end) nxt = halt_cond ? ST_HALT : ST_IDLE;
      ST_HALT: if (!halt_cond) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      stop_ack    <= 1'b0;
      clk_stop_ok <= 1'b0;
    end else begin
      state       <= nxt;
      stop_ack    <= stop_req;
      clk_stop_ok <= stop_req && (nxt == ST_HALT);
    end
  end

  // R6: a frame in flight keeps going until its last bit
  assert_frame_runs_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && !frame_end) |=> state == ST_XFER);
  // R7: clock-stop permission only outside a frame
  assert_stop_ok_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    clk_stop_ok |-> state == ST_HALT);
  // R10: without freeze enable, debug mode never blocks a push
  assert_no_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && in_valid && !stop_req && !freeze_en) |=> state == ST_XFER);
endmodule

// File: rtl/spi_stop_master.sv
module spi_stop_master #(
  parameter int DATA_W = 8,
  parameter int NUM_CS = 6,
  parameter int HALF   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freeze_en,
  input  logic              dbg_mode,
  input  logic              stop_req,
  output logic              stop_ack,
  output logic              clk_stop_ok,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [2:0]        in_cs,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              sout,
  input  logic              sin,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int CSW = 3;

  logic load, run, rise_stb, fall_stb, frame_end;

  spi_ctrl u_ctrl (
    .clk, .rst, .freeze_en, .dbg_mode, .stop_req, .in_valid,
    .frame_end, .in_ready, .load, .run, .stop_ack, .clk_stop_ok
  );

  spi_sck_phase #(.HALF(HALF)) u_phase (
    .clk, .rst, .run, .sck, .rise_stb, .fall_stb
  );

  spi_shift #(.W(DATA_W)) u_shift (
    .clk, .rst, .load, .load_data(in_data), .rise_stb, .fall_stb,
    .sin, .sout, .frame_end, .rx_valid, .rx_data
  );

  spi_cs_dec #(.NCS(NUM_CS), .CSW(CSW)) u_cs (
    .clk, .rst, .load, .idx(in_cs), .release_cs(frame_end), .cs_n
  );

  // R5: acknowledge tracks the request one cycle later
  assert_ack_follows_R5: assert property (@(posedge clk) disable iff (rst)
    stop_ack == $past(stop_req));
  // R7: while clock stop is granted the bus is quiet
  assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    clk_stop_ok |-> (&cs_n && !sck));
  // R8: no word taken while stop is held
  assert_no_accept_R8: assert property (@(posedge clk) disable iff (rst)
    stop_req |-> !in_ready);
endmodule

// File: tb/sim_spi_stop_master.sv
module sim_spi_stop_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic freeze_en = 1'b0, dbg_mode = 1'b0, stop_req = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] in_cs = '0;
  logic stop_ack, clk_stop_ok, in_ready, rx_valid, sck, sout, sin;
  logic [7:0] rx_data;
  logic [5:0] cs_n;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  assign sin = sout;

  spi_stop_master u0 (
    .clk, .rst, .freeze_en, .dbg_mode, .stop_req, .stop_ack, .clk_stop_ok,
    .in_valid, .in_ready, .in_data, .in_cs, .rx_valid, .rx_data,
    .sck, .sout, .sin, .cs_n
  );

  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'hA5}, {3'd1, 8'h3C}, {3'd2, 8'hFF},
    {3'd3, 8'h00}, {3'd4, 8'h81}, {3'd5, 8'h5A}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_cs = c;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_neg(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_neg(4);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 6'h3F);
    chk("R1 sck", sck, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 outs", {rx_valid, stop_ack, clk_stop_ok}, 0);

    // Vector table: R2 R3 R4
    for (int v = 0; v < 6; v++) begin
      push(VEC[v][7:0], VEC[v][10:8]);
      wait_neg(1);
      chk("R4 sout bit7", sout, VEC[v][7]);
      chk("R3 cs_n", cs_n, ~(6'd1 << VEC[v][10:8]) & 6'h3F);
      wait_neg(1); chk("R4 sck low", sck, 0);
      wait_neg(1); chk("R4 sck rise", sck, 1);
      wait_neg(2);
      chk("R4 sck fall", sck, 0);
      chk("R4 sout bit6", sout, VEC[v][6]);
      wait_neg(27);
      chk("R2 no early rx", rx_valid, 0);
      chk("R3 cs held", cs_n, ~(6'd1 << VEC[v][10:8]) & 6'h3F);
      wait_neg(1);
      chk("R2 rx_valid", rx_valid, 1);
      chk("R2 rx_data", rx_data, VEC[v][7:0]);
      chk("R3 cs idle", cs_n, 6'h3F);
      wait_neg(1);
      chk("R2 pulse", rx_valid, 0);
    end

    // R5 R6 R7 R8: stop mid-frame
    push(8'hC3, 3'd2);
    wait_neg(5);
    stop_req = 1'b1;
    wait_neg(1);
    chk("R5 ack rise", stop_ack, 1);
    chk("R7 not yet", clk_stop_ok, 0);
    wait_neg(14);
    chk("R6 cs still low", cs_n, 6'h3B);
    wait_neg(13);
    chk("R6 rx_valid", rx_valid, 1);
    chk("R6 rx_data", rx_data, 8'hC3);
    chk("R7 stop ok", clk_stop_ok, 1);
    chk("R7 quiet", {cs_n, sck}, 7'h7E);
    chk("R8 ready low", in_ready, 0);
    in_valid = 1'b1; in_data = 8'h11; in_cs = 3'd0;
    wait_neg(10);
    chk("R8 no frame", cs_n, 6'h3F);
    in_valid = 1'b0;
    stop_req = 1'b0;
    wait_neg(1);
    chk("R5 ack fall", stop_ack, 0);
    chk("R11 stop ok fall", clk_stop_ok, 0);
    wait_neg(1);
    chk("R11 ready back", in_ready, 1);
    push(8'h6E, 3'd1);
    wait_neg(33);
    chk("R11 resume data", rx_data, 8'h6E);

    // R7: stop while idle
    @(negedge clk); stop_req = 1'b1;
    wait_neg(1);
    chk("R7 idle grant", clk_stop_ok, 1);
    @(negedge clk); stop_req = 1'b0;
    wait_neg(2);

    // R10: debug without freeze enable
    dbg_mode = 1'b1; freeze_en = 1'b0;
    push(8'h96, 3'd4);
    wait_neg(33);
    chk("R10 frame ok", rx_data, 8'h96);
    chk("R10 rx_valid", rx_valid, 1);

    // R9: freeze while idle
    freeze_en = 1'b1;
    wait_neg(1);
    chk("R9 ready low", in_ready, 0);
    in_valid = 1'b1; in_data = 8'h22;
    wait_neg(8);
    chk("R9 no frame", cs_n, 6'h3F);
    chk("R9 no clk stop", clk_stop_ok, 0);
    in_valid = 1'b0; dbg_mode = 1'b0;
    wait_neg(2);
    chk("R11 unfreeze", in_ready, 1);

    // R9: freeze mid-frame
    push(8'h4B, 3'd5);
    wait_neg(8);
    dbg_mode = 1'b1;
    wait_neg(12);
    chk("R9 frame continues", cs_n, 6'h1F);
    wait_neg(13);
    chk("R9 frame done", rx_data, 8'h4B);
    chk("R9 halted", in_ready, 0);
    dbg_mode = 1'b0; freeze_en = 1'b0;
    wait_neg(2);
    chk("R11 ready after", in_ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule